// File: doc/BRIEF.md
# Audio Buffer Pointer Controller

This block sits between an audio serial port and system memory and owns the memory side of its buffers. Software loads a transmit buffer address, a receive buffer address and one buffer length in bytes that both directions share. A start pulse copies those values into working registers. From then on, every word the serial side asks for or hands over becomes one 32-bit access on a simple request/ready memory port. Each access goes to the next word address.

When a direction has moved the whole buffer, it takes the address that software has queued in the meantime. It raises that direction's pointer-taken event, so software can queue the following buffer while the current one drains. Each event stays set until software clears it. Each event has an interrupt enable with separate set and clear strobes. The block checks every descriptor before it uses it and refuses bad ones with an error code.

Top module: `audio_dma_ptr_ctrl`

## Requirements
- R1: After reset, `evt`, `irq`, `err`, `busy`, `mem_req` and `tx_word_vld` are all 0.
- R2: A `start` pulse accepted while idle, with a valid descriptor, has these effects at the same clock edge: it copies the queued address of each enabled direction, sets `busy`, and sets `evt` bit 0 (transmit) and/or bit 1 (receive) for each enabled direction.
- R3: The word count is the byte length rounded up to whole 32-bit words. Each `tx_pull` produces one memory read at the current transmit address, which then advances by 4. The read word appears on `tx_word`, with `tx_word_vld` high for one cycle, three clock edges after the edge that samples `tx_pull`.
- R4: Each `rx_push` writes `rx_word` to the current receive address with `mem_we` = 1, and that address then advances by 4. The write completes three edges after the edge that samples the push.
- R5: After the last word of a buffer, the direction loads the address queued at that moment and sets its event again at the same edge. Addresses written while a buffer is running do not change that buffer.
- R6: A start whose enabled pointer has address bits [1:0] not equal to 0 is refused. It sets `err` = 4'b0001 and starts nothing.
- R7: A start whose enabled pointer lies outside the window from 0x2000_0000 up to but not including 0x3000_0000 is refused with `err` = 4'b0010. 0x2FFF_FFFC is accepted.
- R8: A zero length is refused with `err` = 4'b0100. A length of more than 16384 words is refused with `err` = 4'b1000. A length of exactly 16384 words (65536 bytes) is accepted. An accepted start sets `err` to 0.
- R9: Each `evt` bit stays set until its `evt_clr` bit is pulsed. A new event in the same cycle as a clear leaves the bit set.
- R10: `ien_set` and `ien_clr` set and clear the per-direction interrupt enables. `irq` is high exactly when an event bit and its enable are both set, and it changes at the same edge as they do.
- R11: Dropping `tx_en` while transmit runs stops transmit at the next edge and sets `evt` bit 0. No further transmit memory request follows. `busy` falls once both directions have stopped.
- R12: When both directions have a word waiting, the receive write is issued first. A memory request keeps its address, direction and data unchanged until `mem_ready`.
- R13: A `start` pulse while `busy` is ignored: the errors, the events and the running state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ptr_wr | input | 1 | Queue `ptr_wdata` as the next transmit address |
| rx_ptr_wr | input | 1 | Queue `ptr_wdata` as the next receive address |
| ptr_wdata | input | 32 | Buffer address to queue |
| len_wr | input | 1 | Load the shared buffer length |
| len_bytes | input | LEN_W | Buffer length in bytes |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| start | input | 1 | Begin transfers with the queued descriptors |
| evt_clr | input | 2 | Clear event bits (bit 0 transmit, bit 1 receive) |
| ien_set | input | 2 | Set interrupt enables |
| ien_clr | input | 2 | Clear interrupt enables |
| tx_pull | input | 1 | Serial side requests the next transmit word |
| tx_word | output | 32 | Transmit word read from memory |
| tx_word_vld | output | 1 | `tx_word` is valid this cycle |
| rx_push | input | 1 | Serial side delivers a received word |
| rx_word | input | 32 | Received word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write (receive), 0 for read (transmit) |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts/completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| evt | output | 2 | Sticky pointer-taken events |
| irq | output | 1 | Interrupt request |
| err | output | 4 | Descriptor fault code of the last check |
| busy | output | 1 | At least one direction is running |

## Verification
Configuration, start, stop, event, enable and error results are all due at the first clock edge after the edge that samples the stimulus. The bench drives on the falling edge and checks on the next falling edge. A data word takes three edges: the pending flag is set, the request is issued, then the bench memory answers one cycle later and the access completes. The bench first checks that `tx_word_vld` is still low two falling edges after the pull, then checks the word one edge later. It checks receive memory contents at that same point. The reload event is checked at the same sample as the final word of a buffer.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int ERR_W  = 4;
  localparam int NCH    = 2;   // channel 0 = transmit, 1 = receive
  typedef logic [ADDR_W-1:0] addr_t;

  // bit 0: misaligned, bit 1: outside the memory window [lo, hi)
  function automatic logic [1:0] ptr_fault(input addr_t p, input addr_t lo, input addr_t hi);
    return {(p < lo) || (p >= hi), p[1:0] != 2'b00};
  endfunction
endpackage

// File: rtl/adma_chan.sv
module adma_chan import adma_pkg::*; #(
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_go,
  input  logic           en,
  input  addr_t          shadow_ptr,
  input  logic [WCW-1:0] words,
  input  logic           shadow_ok,
  input  logic           req_in,
  input  logic           done,
  output logic           act,
  output logic           pend,
  output addr_t          addr,
  output logic           upd_now,
  output logic           reload_bad
);
  logic [WCW-1:0] left_q;
  logic           last, reload_ok, stop_now;

  assign last       = done && act && (left_q == WCW'(1));
  assign reload_ok  = last && shadow_ok;
  assign reload_bad = last && !shadow_ok && en;
  assign stop_now   = act && !en;
  assign upd_now    = start_go || (reload_ok && en) || stop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      pend   <= 1'b0;
      addr   <= '0;
      left_q <= '0;
    end else if (start_go) begin
      act    <= 1'b1;
      pend   <= 1'b0;
      addr   <= shadow_ptr;
      left_q <= words;
    end else if (stop_now) begin
      act  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (done && act) begin
        pend <= 1'b0;
        if (last) begin
          if (reload_ok) begin
            addr   <= shadow_ptr;
            left_q <= words;
          end else begin
            act <= 1'b0;
          end
        end else begin
          addr   <= addr + ADDR_W'(4);
          left_q <= left_q - WCW'(1);
        end
      end
      if (req_in && act) pend <= 1'b1;
    end
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (done && act && en && left_q != WCW'(1)) |=> (addr == $past(addr) + ADDR_W'(4)));
  // R11
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (act && !en) |=> !act);
  // R6
  align_chk: assert property (@(posedge clk) disable iff (rst)
    act |-> (addr[1:0] == 2'b00));
endmodule

// File: rtl/adma_arb.sv
module adma_arb import adma_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pend,
  input  addr_t             tx_addr,
  input  addr_t             rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_we,
  output addr_t             mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [NCH-1:0]    done,
  output logic              idle
);
  logic own_rx_q, fin;

  assign fin  = mem_req && mem_ready;
  assign done = {fin && own_rx_q, fin && !own_rx_q};
  assign idle = !mem_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      own_rx_q  <= 1'b0;
    end else if (fin) begin
      mem_req <= 1'b0;
    end else if (!mem_req && (|pend)) begin
      mem_req   <= 1'b1;
      own_rx_q  <= pend[1];
      mem_we    <= pend[1];
      mem_addr  <= pend[1] ? rx_addr : tx_addr;
      mem_wdata <= rx_data;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R12
  rx_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && pend[0] && pend[1]) |=> (mem_req && mem_we));
endmodule

// File: rtl/audio_dma_ptr_ctrl.sv
module audio_dma_ptr_ctrl import adma_pkg::*; #(
  parameter int    LEN_W    = 17,
  parameter int    CNT_BITS = 14,
  parameter addr_t RAM_LO   = 32'h2000_0000,
  parameter addr_t RAM_HI   = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_ptr_wr,
  input  logic              rx_ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wdata,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              start,
  input  logic [1:0]        evt_clr,
  input  logic [1:0]        ien_set,
  input  logic [1:0]        ien_clr,
  input  logic              tx_pull,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_word_vld,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        evt,
  output logic              irq,
  output logic [ERR_W-1:0]  err,
  output logic              busy
);
  localparam int WCW = LEN_W - 1;
  localparam logic [WCW-1:0] MAX_WORDS = WCW'(1) << CNT_BITS;

  addr_t             sh_ptr [NCH];
  addr_t             ch_addr[NCH];
  logic [1:0]        sh_flt [NCH];
  logic [WCW-1:0]    words_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic [1:0]        cnt_flt, ptr_start_flt, ptr_bad_flt, ien_q, evt_d, ien_d;
  logic [NCH-1:0]    act, pend, upd, bad, go_ch, en_v, req_v, done_v;
  logic              go, go_ok, arb_idle;
  logic [LEN_W:0]    len_sum;

  assign len_sum = {1'b0, len_bytes} + (LEN_W+1)'(3);
  assign en_v    = {rx_en, tx_en};
  assign req_v   = {rx_push, tx_pull};
  assign busy    = |act;
  assign cnt_flt = {words_q > MAX_WORDS, words_q == '0};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_ptr[0] <= '0;
      sh_ptr[1] <= '0;
      words_q   <= '0;
      rx_buf_q  <= '0;
    end else begin
      if (tx_ptr_wr) sh_ptr[0] <= ptr_wdata;
      if (rx_ptr_wr) sh_ptr[1] <= ptr_wdata;
      if (len_wr)    words_q   <= len_sum[LEN_W:2];
      if (rx_push)   rx_buf_q  <= rx_word;
    end
  end

  assign sh_flt[0]     = ptr_fault(sh_ptr[0], RAM_LO, RAM_HI);
  assign sh_flt[1]     = ptr_fault(sh_ptr[1], RAM_LO, RAM_HI);
  assign ptr_start_flt = (tx_en ? sh_flt[0] : 2'b00) | (rx_en ? sh_flt[1] : 2'b00);
  assign ptr_bad_flt   = (bad[0] ? sh_flt[0] : 2'b00) | (bad[1] ? sh_flt[1] : 2'b00);
  assign go            = start && !busy && arb_idle && (tx_en || rx_en);
  assign go_ok         = go && (cnt_flt == 2'b00) && (ptr_start_flt == 2'b00);
  assign go_ch         = go_ok ? en_v : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    adma_chan #(.WCW(WCW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .start_go   (go_ch[c]),
      .en         (en_v[c]),
      .shadow_ptr (sh_ptr[c]),
      .words      (words_q),
      .shadow_ok  ((sh_flt[c] == 2'b00) && (cnt_flt == 2'b00)),
      .req_in     (req_v[c]),
      .done       (done_v[c]),
      .act        (act[c]),
      .pend       (pend[c]),
      .addr       (ch_addr[c]),
      .upd_now    (upd[c]),
      .reload_bad (bad[c])
    );
  end

  adma_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .tx_addr   (ch_addr[0]),
    .rx_addr   (ch_addr[1]),
    .rx_data   (rx_buf_q),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done_v),
    .idle      (arb_idle)
  );

  assign evt_d = (evt & ~evt_clr) | upd;
  assign ien_d = (ien_q & ~ien_clr) | ien_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt         <= '0;
      ien_q       <= '0;
      irq         <= 1'b0;
      err         <= '0;
      tx_word     <= '0;
      tx_word_vld <= 1'b0;
    end else begin
      evt         <= evt_d;
      ien_q       <= ien_d;
      irq         <= |(evt_d & ien_d);
      tx_word_vld <= done_v[0] && act[0];
      if (done_v[0]) tx_word <= mem_rdata;
      if (go)             err <= {cnt_flt, ptr_start_flt};
      else if (|bad)      err <= {cnt_flt, ptr_bad_flt};
    end
  end

  // R9
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt[0] && !evt_clr[0]) |=> evt[0]);
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(evt & ien_q));
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && words_q == '0) |=> !busy);
  // R13
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !(|bad) && !(|upd)) |=> $stable(err));
endmodule

// File: tb/audio_dma_ptr_ctrl_bench.sv
`timescale 1ns/1ps
module audio_dma_ptr_ctrl_bench;
  logic        clk = 1'b0, rst = 1'b1;
  logic        tx_ptr_wr = 0, rx_ptr_wr = 0, len_wr = 0, tx_en = 0, rx_en = 0, start = 0;
  logic [31:0] ptr_wdata = '0;
  logic [16:0] len_bytes = '0;
  logic [1:0]  evt_clr = '0, ien_set = '0, ien_clr = '0;
  logic        tx_pull = 0, rx_push = 0;
  logic [31:0] rx_word = '0;
  logic [31:0] tx_word, mem_addr, mem_wdata, mem_rdata;
  logic        tx_word_vld, mem_req, mem_we, irq, busy;
  logic        mem_ready = 1'b0;
  logic [1:0]  evt;
  logic [3:0]  err;
  logic [31:0] mem [64];
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  audio_dma_ptr_ctrl u_audio_dma_ptr_ctrl (
    .clk(clk), .rst(rst), .tx_ptr_wr(tx_ptr_wr), .rx_ptr_wr(rx_ptr_wr), .ptr_wdata(ptr_wdata),
    .len_wr(len_wr), .len_bytes(len_bytes), .tx_en(tx_en), .rx_en(rx_en), .start(start),
    .evt_clr(evt_clr), .ien_set(ien_set), .ien_clr(ien_clr), .tx_pull(tx_pull),
    .tx_word(tx_word), .tx_word_vld(tx_word_vld), .rx_push(rx_push), .rx_word(rx_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .evt(evt), .irq(irq), .err(err), .busy(busy));

  // memory model: answers one cycle after a request appears
  assign mem_rdata = mem[mem_addr[7:2]];
  always_ff @(posedge clk) begin
    mem_ready <= mem_req && !mem_ready;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic wr_tx(input logic [31:0] p); ptr_wdata = p; tx_ptr_wr = 1; step(); tx_ptr_wr = 0; endtask
  task automatic wr_rx(input logic [31:0] p); ptr_wdata = p; rx_ptr_wr = 1; step(); rx_ptr_wr = 0; endtask
  task automatic wr_len(input logic [16:0] n); len_bytes = n; len_wr = 1; step(); len_wr = 0; endtask
  task automatic kick(); start = 1; step(); start = 0; endtask
  task automatic clr_evt(); evt_clr = 2'b11; step(); evt_clr = 2'b00; endtask

  task automatic pull_tx(input logic [31:0] exp, input string tag);
    tx_pull = 1; step(); tx_pull = 0;
    step(); step();
    chk(tx_word_vld == 1'b0, tag, {31'd0, tx_word_vld}, 32'd0);
    step();
    chk(tx_word_vld == 1'b1, tag, {31'd0, tx_word_vld}, 32'd1);
    chk(tx_word == exp, tag, tx_word, exp);
  endtask

  task automatic push_rx(input logic [31:0] val, input int idx, input string tag);
    rx_word = val; rx_push = 1; step(); rx_push = 0;
    step(); step(); step();
    chk(mem[idx] == val, tag, mem[idx], val);
  endtask

  task automatic t_reset();
    chk(evt == 0 && irq == 0 && err == 0, "R1 flags", {25'd0, evt, irq, err}, 32'd0);
    chk(busy == 0 && mem_req == 0 && tx_word_vld == 0, "R1 idle", {29'd0, busy, mem_req, tx_word_vld}, 32'd0);
  endtask

  task automatic t_tx();
    wr_tx(32'h2000_0000); wr_len(17'd6); tx_en = 1; kick();
    chk(evt == 2'b01, "R2 tx event", {30'd0, evt}, 32'd1);
    chk(busy == 1 && err == 0, "R2 busy", {27'd0, busy, err}, 32'h10);
    clr_evt();
    wr_tx(32'h2000_0020);
    pull_tx(32'hA000_0000, "R3 word0");
    chk(evt == 2'b00, "R5 no early event", {30'd0, evt}, 32'd0);
    pull_tx(32'hA000_0001, "R3 word1 rounded count");
    chk(evt == 2'b01, "R5 reload event", {30'd0, evt}, 32'd1);
    pull_tx(32'hA000_0008, "R5 next buffer");
    clr_evt();
    tx_en = 0; step();
    chk(evt == 2'b01 && busy == 0, "R11 stop event", {29'd0, busy, evt}, 32'd1);
    tx_pull = 1; step(); tx_pull = 0;
    for (int i = 0; i < 4; i++) begin
      chk(mem_req == 0 && tx_word_vld == 0, "R11 no request", {30'd0, mem_req, tx_word_vld}, 32'd0);
      step();
    end
    clr_evt();
  endtask

  task automatic t_rx();
    wr_rx(32'h2000_0040); wr_len(17'd8); rx_en = 1; kick();
    chk(evt == 2'b10, "R2 rx event", {30'd0, evt}, 32'd2);
    clr_evt();
    wr_rx(32'h2000_0050);
    push_rx(32'h1111_1111, 16, "R4 word0");
    push_rx(32'h2222_2222, 17, "R4 word1");
    chk(evt == 2'b10, "R5 rx reload event", {30'd0, evt}, 32'd2);
    push_rx(32'h3333_3333, 20, "R5 rx next buffer");
    rx_en = 0; step(); clr_evt();
    chk(busy == 0, "R11 rx stopped", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_prio();
    logic seen;
    seen = 1'b0;
    wr_tx(32'h2000_0000); wr_rx(32'h2000_0080); wr_len(17'd4);
    tx_en = 1; rx_en = 1; kick(); clr_evt();
    rx_word = 32'h5555_AAAA; tx_pull = 1; rx_push = 1; step(); tx_pull = 0; rx_push = 0;
    step();
    chk(mem_req && mem_we && mem_addr == 32'h2000_0080, "R12 rx first", mem_addr, 32'h2000_0080);
    for (int i = 0; i < 10 && !seen; i++) begin
      step();
      if (tx_word_vld) seen = 1'b1;
    end
    chk(seen, "R12 tx served after", {31'd0, seen}, 32'd1);
    chk(tx_word == 32'hA000_0000, "R12 tx data", tx_word, 32'hA000_0000);
    chk(mem[32] == 32'h5555_AAAA, "R12 rx data", mem[32], 32'h5555_AAAA);
    tx_en = 0; rx_en = 0; step(); clr_evt();
  endtask

  task automatic t_err();
    tx_en = 1; wr_len(17'd4);
    wr_tx(32'h2000_0002); kick();
    chk(err == 4'b0001 && busy == 0 && evt == 0, "R6 misaligned", {27'd0, busy, err}, 32'h1);
    wr_tx(32'h1FFF_FFFC); kick();
    chk(err == 4'b0010 && busy == 0, "R7 below window", {27'd0, busy, err}, 32'h2);
    wr_tx(32'h3000_0000); kick();
    chk(err == 4'b0010 && busy == 0, "R7 window end", {27'd0, busy, err}, 32'h2);
    wr_tx(32'h2FFF_FFFC); kick();
    chk(err == 4'b0000 && busy == 1, "R7 last word ok", {27'd0, busy, err}, 32'h10);
    tx_en = 0; step(); clr_evt(); tx_en = 1;
    wr_tx(32'h2000_0000); wr_len(17'd0); kick();
    chk(err == 4'b0100 && busy == 0, "R8 zero length", {27'd0, busy, err}, 32'h4);
    wr_len(17'd65537); kick();
    chk(err == 4'b1000 && busy == 0, "R8 too long", {27'd0, busy, err}, 32'h8);
    wr_len(17'd65536); kick();
    chk(err == 4'b0000 && busy == 1, "R8 max length ok", {27'd0, busy, err}, 32'h10);
    clr_evt();
    wr_tx(32'h2000_0001); kick();
    chk(err == 0 && evt == 0 && busy == 1, "R13 start while busy", {25'd0, busy, evt, err}, 32'h40);
    tx_en = 0; step(); clr_evt();
  endtask

  task automatic t_irq();
    ien_set = 2'b01; step(); ien_set = 0;
    wr_tx(32'h2000_0000); wr_len(17'd4); tx_en = 1; kick();
    chk(evt == 2'b01 && irq == 1, "R10 irq with event", {29'd0, irq, evt}, 32'h5);
    ien_clr = 2'b01; step(); ien_clr = 0;
    chk(irq == 0 && evt == 2'b01, "R10 irq masked", {29'd0, irq, evt}, 32'h1);
    clr_evt();
    chk(evt == 0, "R9 cleared", {30'd0, evt}, 32'd0);
    evt_clr = 2'b01; tx_en = 0; step(); evt_clr = 0;
    chk(evt == 2'b01, "R9 set beats clear", {30'd0, evt}, 32'd1);
    step();
    chk(evt == 2'b01, "R9 held", {30'd0, evt}, 32'd1);
    clr_evt();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i;
    repeat (3) step();
    rst = 0; step();
    t_reset();
    t_tx();
    t_rx();
    t_prio();
    t_err();
    t_irq();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule